// File: doc/BRIEF.md
# Data Address Translation Unit

This block turns the virtual address of a load or store into a physical address, or reports exactly one fault for it. A request arrives on a valid/ready stream and carries the address, the access size, a store flag and three qualifiers: physical access, alternate-mode access and page-table access. Plain control inputs supply the current privilege mode, the alternate mode, the low bit of the program counter and the address-space number. The unit first checks alignment, then checks the form of the address. It then either passes the address through unchanged, maps a kernel superpage window directly, or queries an external translation buffer through a combinational lookup port. After that it checks the permission and fault-on-access bits of the entry, rejects physical addresses beyond the implemented range, and classifies cacheability from the top physical bit.

Results leave on a second valid/ready stream, one for each accepted request and in order. The result holds the physical address, an uncacheable flag, a fault code and a six-bit status word. The output holds one register stage. A new request is taken whenever that stage is empty or its content is being consumed in the same cycle (`in_ready = !out_valid || out_ready`). A stalled result stays unchanged until it is taken. The translation storage, address-space matching and global-entry matching sit behind the lookup port and are not part of this block.

Privilege modes are encoded kernel=0, executive=1, supervisor=2, user=3. Bit *m* of a read-enable or write-enable mask grants access in mode *m*. Fault codes are: 0 none, 1 alignment, 2 page fault, 3 access violation, 4 page-table-access miss, 5 normal miss, 6 machine check. Status bits are: bit0 store, bit1 access violation, bit2 fault-on-read, bit3 fault-on-write, bit4 translation miss, bit5 bad virtual address.

Top module: `data_xlate`

## Requirements
- R1: A result is produced for every accepted request, in order. While `out_valid` is high and `out_ready` is low, every output field stays unchanged. After reset `out_valid` is 0 and `in_ready` is 1.
- R2: If `va & ((1<<size_log2)-1)` is nonzero, the fault is alignment (1) with status equal to the store bit alone. This check wins over every other check, including a malformed address.
- R3: The effective mode for permission checks is `alt_mode` when `pc_lsb` and `in_alt` are both 1, kernel when `pc_lsb` is 1 and `in_alt` is 0, and `cur_mode` when `pc_lsb` is 0.
- R4: On a non-physical access whose bits 47:42 are not all equal, the fault is page fault (2) with status bad-VA|ACV (0x22), plus the store bit for stores.
- R5: A non-physical address with bits 47:41 equal to 0x7E is a superpage. If `cur_mode` is not kernel, the fault is access violation (3) with status ACV plus the store bit; the effective mode is not consulted. If `cur_mode` is kernel, the candidate address is VA bits 39:0 with bit 40 copied into bits 43:40, and no lookup is made.
- R6: On a lookup miss the status is translation-miss (0x10) plus the store bit. The fault is 4 when `in_pte` is set and 5 otherwise.
- R7: On a hit the candidate address is `{ppn, va[12:0]}`.
- R8: A store whose write mask lacks the effective-mode bit gives page fault with WR|ACV, plus FONW if the entry has fault-on-write. A permitted store to a fault-on-write entry gives page fault with WR|FONW.
- R9: A load whose read mask lacks the effective-mode bit gives access violation with ACV, plus FONR if the entry has fault-on-read. A permitted load to a fault-on-read entry gives page fault with FONR only.
- R10: A physical access uses the VA as the candidate address unchanged. It skips the address-form, superpage and permission checks and makes no lookup.
- R11: A candidate address with any bit at or above bit 44 set gives machine check (6) with status 0.
- R12: Otherwise `out_uncached` equals bit 43 of the candidate. When that bit is set, bits 42:35 of the output address are cleared.
- R13: Whenever the fault code is nonzero, `out_pa` is 0 and `out_uncached` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request valid |
| in_ready | output | 1 | Request accepted this cycle when high with in_valid |
| in_va | input | VA_W | Virtual address |
| in_size_log2 | input | SZ_W | Log2 of access size in bytes |
| in_store | input | 1 | 1 for store, 0 for load |
| in_phys | input | 1 | Physical access, no translation |
| in_alt | input | 1 | Use alternate mode when PC low bit is set |
| in_pte | input | 1 | Page-table access, selects miss fault code |
| pc_lsb | input | 1 | Low bit of the current program counter |
| cur_mode | input | 2 | Current privilege mode |
| alt_mode | input | 2 | Alternate privilege mode |
| asn | input | ASN_W | Address-space number |
| tlb_req | output | 1 | Lookup request |
| tlb_vpn | output | VA_W-PAGE_SHIFT | Virtual page number to look up |
| tlb_asn | output | ASN_W | Address-space number to match |
| tlb_hit | input | 1 | Lookup found an entry |
| tlb_ppn | input | PPN_W | Physical page number of the entry |
| tlb_rd_en | input | 4 | Read-enable mask by mode |
| tlb_wr_en | input | 4 | Write-enable mask by mode |
| tlb_fonr | input | 1 | Entry faults on read |
| tlb_fonw | input | 1 | Entry faults on write |
| out_valid | output | 1 | Result valid |
| out_ready | input | 1 | Result consumed this cycle when high with out_valid |
| out_pa | output | PA_W | Physical address |
| out_uncached | output | 1 | Access is uncacheable |
| out_fault | output | 3 | Fault code |
| out_status | output | 6 | Status word |

## Verification
The bench builds the unit with its defaults: a 48-bit VA, a 44-bit PA, 8 KiB pages and a 32-bit PPN. That PPN is one bit wider than a 44-bit address needs, so a translated address can overflow into bit 44 and reach the machine-check path, and a single PPN bit can hit the uncacheable bit 43. A small translation table in the bench answers the lookup port. Its entries cover each combination of read and write masks and fault-on-access bits. A throttled `out_ready` pattern keeps results stalled, so ordering and hold behaviour are exercised while the addresses are checked.

// File: rtl/datu_pkg.sv
package datu_pkg;

  typedef enum logic [2:0] {
    FLT_NONE  = 3'd0,
    FLT_ALIGN = 3'd1,
    FLT_PAGE  = 3'd2,
    FLT_ACV   = 3'd3,
    FLT_PMISS = 3'd4,
    FLT_NMISS = 3'd5,
    FLT_MCHK  = 3'd6
  } fault_e;

  localparam int ST_W     = 6;
  localparam int ST_WR    = 0;
  localparam int ST_ACV   = 1;
  localparam int ST_FONR  = 2;
  localparam int ST_FONW  = 3;
  localparam int ST_MISS  = 4;
  localparam int ST_BADVA = 5;

  localparam int MODE_W = 2;
  localparam int NMODES = 1 << MODE_W;
  localparam logic [MODE_W-1:0] MODE_KERNEL = '0;

endpackage

// File: rtl/datu_mode_sel.sv
module datu_mode_sel
  import datu_pkg::*;
(
  input  logic              pc_lsb,
  input  logic              use_alt,
  input  logic [MODE_W-1:0] cur_mode,
  input  logic [MODE_W-1:0] alt_mode,
  output logic [MODE_W-1:0] eff_mode
);

  // low PC bit marks privileged code: its accesses run as kernel unless
  // the request asks for the alternate mode
  always_comb begin
    if (!pc_lsb)      eff_mode = cur_mode;
    else if (use_alt) eff_mode = alt_mode;
    else              eff_mode = MODE_KERNEL;
  end

endmodule

// File: rtl/datu_perm_chk.sv
module datu_perm_chk
  import datu_pkg::*;
(
  input  logic              is_store,
  input  logic [MODE_W-1:0] eff_mode,
  input  logic [NMODES-1:0] rd_en,
  input  logic [NMODES-1:0] wr_en,
  input  logic              fonr,
  input  logic              fonw,
  output fault_e            pfault,
  output logic [ST_W-1:0]   pstat
);

  logic granted;

  always_comb begin
    granted = is_store ? wr_en[eff_mode] : rd_en[eff_mode];
    pfault  = FLT_NONE;
    pstat   = '0;
    if (is_store) begin
      pstat[ST_WR] = 1'b1;
      if (!granted) begin
        pfault         = FLT_PAGE;
        pstat[ST_ACV]  = 1'b1;
        pstat[ST_FONW] = fonw;
      end else if (fonw) begin
        pfault         = FLT_PAGE;
        pstat[ST_FONW] = 1'b1;
      end else begin
        pstat = '0;
      end
    end else begin
      if (!granted) begin
        pfault         = FLT_ACV;
        pstat[ST_ACV]  = 1'b1;
        pstat[ST_FONR] = fonr;
      end else if (fonr) begin
        pfault         = FLT_PAGE;
        pstat[ST_FONR] = 1'b1;
      end
    end
  end

endmodule

// File: rtl/datu_pa_fin.sv
module datu_pa_fin #(
  parameter int CHK_W  = 48,
  parameter int PA_W   = 44,
  parameter int CLR_LO = 35
) (
  input  logic [CHK_W-1:0] cand,
  output logic             mchk,
  output logic [PA_W-1:0]  pa,
  output logic             uc
);

  localparam int UC_BIT = PA_W - 1;

  logic [PA_W-1:0] keep;

  // bits between CLR_LO and the uncacheable bit are dropped on uncached accesses
  for (genvar g = 0; g < PA_W; g++) begin : g_keep
    assign keep[g] = (g >= CLR_LO && g < UC_BIT) ? 1'b0 : 1'b1;
  end

  assign mchk = |cand[CHK_W-1:PA_W];
  assign uc   = cand[UC_BIT];
  assign pa   = uc ? (cand[PA_W-1:0] & keep) : cand[PA_W-1:0];

endmodule

// File: rtl/data_xlate.sv
module data_xlate
  import datu_pkg::*;
#(
  parameter int VA_W       = 48,
  parameter int PA_W       = 44,
  parameter int PAGE_SHIFT = 13,
  parameter int PPN_W      = 32,
  parameter int ASN_W      = 8,
  parameter int SZ_W       = 2,
  parameter int VALID_MSB  = 42,
  parameter int SP_HI      = 47,
  parameter int SP_LO      = 41,
  parameter int SP_TAG     = 126,
  parameter int SP_SIGN    = 40,
  parameter int CLR_LO     = 35
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       in_valid,
  output logic                       in_ready,
  input  logic [VA_W-1:0]            in_va,
  input  logic [SZ_W-1:0]            in_size_log2,
  input  logic                       in_store,
  input  logic                       in_phys,
  input  logic                       in_alt,
  input  logic                       in_pte,
  input  logic                       pc_lsb,
  input  logic [1:0]                 cur_mode,
  input  logic [1:0]                 alt_mode,
  input  logic [ASN_W-1:0]           asn,
  output logic                       tlb_req,
  output logic [VA_W-PAGE_SHIFT-1:0] tlb_vpn,
  output logic [ASN_W-1:0]           tlb_asn,
  input  logic                       tlb_hit,
  input  logic [PPN_W-1:0]           tlb_ppn,
  input  logic [3:0]                 tlb_rd_en,
  input  logic [3:0]                 tlb_wr_en,
  input  logic                       tlb_fonr,
  input  logic                       tlb_fonw,
  output logic                       out_valid,
  input  logic                       out_ready,
  output logic [PA_W-1:0]            out_pa,
  output logic                       out_uncached,
  output logic [2:0]                 out_fault,
  output logic [5:0]                 out_status
);

  localparam int FULL_W = PPN_W + PAGE_SHIFT;
  localparam int CHK_W  = (VA_W > FULL_W) ? VA_W : FULL_W;
  localparam int SP_W   = SP_HI - SP_LO + 1;

  logic [VA_W-1:0]      amask;
  logic                 misaligned, va_ok, is_sp;
  logic [PA_W-1:0]      sp_pa;
  logic [MODE_W-1:0]    eff_mode;
  fault_e               pfault;
  logic [ST_W-1:0]      pstat;
  logic [CHK_W-1:0]     cand;
  logic                 use_cand;
  logic                 fin_mchk, fin_uc;
  logic [PA_W-1:0]      fin_pa;
  fault_e               fault_c;
  logic [ST_W-1:0]      stat_c;
  logic [PA_W-1:0]      pa_c;
  logic                 uc_c;

  // request classification
  assign amask      = ({{(VA_W-1){1'b0}}, 1'b1} << in_size_log2) - 1'b1;
  assign misaligned = |(in_va & amask);
  assign va_ok      = (&in_va[VA_W-1:VALID_MSB]) | ~(|in_va[VA_W-1:VALID_MSB]);
  assign is_sp      = in_va[SP_HI:SP_LO] == SP_W'(SP_TAG);
  assign sp_pa      = {{(PA_W-SP_SIGN){in_va[SP_SIGN]}}, in_va[SP_SIGN-1:0]};

  // lookup port
  assign tlb_req = in_valid && !in_phys && !misaligned && va_ok && !is_sp;
  assign tlb_vpn = in_va[VA_W-1:PAGE_SHIFT];
  assign tlb_asn = asn;

  datu_mode_sel u_mode (
    .pc_lsb   (pc_lsb),
    .use_alt  (in_alt),
    .cur_mode (cur_mode),
    .alt_mode (alt_mode),
    .eff_mode (eff_mode)
  );

  datu_perm_chk u_perm (
    .is_store (in_store),
    .eff_mode (eff_mode),
    .rd_en    (tlb_rd_en),
    .wr_en    (tlb_wr_en),
    .fonr     (tlb_fonr),
    .fonw     (tlb_fonw),
    .pfault   (pfault),
    .pstat    (pstat)
  );

  datu_pa_fin #(.CHK_W(CHK_W), .PA_W(PA_W), .CLR_LO(CLR_LO)) u_fin (
    .cand (cand),
    .mchk (fin_mchk),
    .pa   (fin_pa),
    .uc   (fin_uc)
  );

  // fault priority chain: first matching check decides
  always_comb begin
    fault_c          = FLT_NONE;
    stat_c           = '0;
    stat_c[ST_WR]    = in_store;
    cand             = '0;
    use_cand         = 1'b0;
    pa_c             = '0;
    uc_c             = 1'b0;
    if (misaligned) begin
      fault_c = FLT_ALIGN;
    end else if (in_phys) begin
      cand     = CHK_W'(in_va);
      use_cand = 1'b1;
    end else if (!va_ok) begin
      fault_c          = FLT_PAGE;
      stat_c[ST_BADVA] = 1'b1;
      stat_c[ST_ACV]   = 1'b1;
    end else if (is_sp) begin
      if (cur_mode != MODE_KERNEL) begin
        fault_c        = FLT_ACV;
        stat_c[ST_ACV] = 1'b1;
      end else begin
        cand     = CHK_W'(sp_pa);
        use_cand = 1'b1;
      end
    end else if (!tlb_hit) begin
      fault_c         = in_pte ? FLT_PMISS : FLT_NMISS;
      stat_c[ST_MISS] = 1'b1;
    end else begin
      cand = CHK_W'({tlb_ppn, in_va[PAGE_SHIFT-1:0]});
      if (pfault != FLT_NONE) begin
        fault_c = pfault;
        stat_c  = pstat;
      end else begin
        use_cand = 1'b1;
      end
    end
    if (use_cand) begin
      if (fin_mchk) begin
        fault_c = FLT_MCHK;
        stat_c  = '0;
      end else begin
        stat_c = '0;
        pa_c   = fin_pa;
        uc_c   = fin_uc;
      end
    end
  end

  // output stage
  assign in_ready = !out_valid || out_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid    <= 1'b0;
      out_pa       <= '0;
      out_uncached <= 1'b0;
      out_fault    <= FLT_NONE;
      out_status   <= '0;
    end else if (in_ready) begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_pa       <= pa_c;
        out_uncached <= uc_c;
        out_fault    <= fault_c;
        out_status   <= stat_c;
      end
    end
  end

  // checks
  p_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_pa) && $stable(out_fault)
      && $stable(out_status) && $stable(out_uncached));

  p_align_first_r2: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && in_va[0] && (in_size_log2 != '0) |=> out_fault == FLT_ALIGN);

  p_miss_stat_r6: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && (out_fault == FLT_PMISS || out_fault == FLT_NMISS)
      |-> out_status[ST_MISS] && !out_status[ST_ACV]);

  p_phys_nolookup_r10: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_phys |-> !tlb_req);

  p_mchk_stat_r11: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_fault == FLT_MCHK |-> out_status == '0);

  p_fault_clean_r13: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_fault != FLT_NONE |-> out_pa == '0 && !out_uncached);

endmodule

// File: tb/test_data_xlate.sv
module test_data_xlate;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [47:0] in_va = '0;
  logic [1:0]  in_size_log2 = '0;
  logic        in_store = 1'b0, in_phys = 1'b0, in_alt = 1'b0, in_pte = 1'b0;
  logic        pc_lsb = 1'b0;
  logic [1:0]  cur_mode = '0, alt_mode = '0;
  logic [7:0]  asn = 8'h5A;
  logic        tlb_req;
  logic [34:0] tlb_vpn;
  logic [7:0]  tlb_asn;
  logic        tlb_hit;
  logic [31:0] tlb_ppn;
  logic [3:0]  tlb_rd_en, tlb_wr_en;
  logic        tlb_fonr, tlb_fonw;
  logic        out_valid;
  logic        out_ready = 1'b0;
  logic [43:0] out_pa;
  logic        out_uncached;
  logic [2:0]  out_fault;
  logic [5:0]  out_status;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  data_xlate #(.VA_W(48), .PA_W(44), .PAGE_SHIFT(13), .PPN_W(32), .ASN_W(8)) i_data_xlate (
    .clk, .rst_n, .in_valid, .in_ready, .in_va, .in_size_log2, .in_store, .in_phys,
    .in_alt, .in_pte, .pc_lsb, .cur_mode, .alt_mode, .asn, .tlb_req, .tlb_vpn, .tlb_asn,
    .tlb_hit, .tlb_ppn, .tlb_rd_en, .tlb_wr_en, .tlb_fonr, .tlb_fonw, .out_valid,
    .out_ready, .out_pa, .out_uncached, .out_fault, .out_status
  );

  // bench translation table
  localparam int NE = 6;
  logic [34:0] t_vpn [NE] = '{35'h100, 35'h101, 35'h102, 35'h103, 35'h104, 35'h105};
  logic [31:0] t_ppn [NE] = '{32'hABC, 32'h22, 32'h33, 32'h33, 32'h8000_0001, 32'h4000_0123};
  logic [3:0]  t_re  [NE] = '{4'hF, 4'h1, 4'hF, 4'h0, 4'hF, 4'hF};
  logic [3:0]  t_we  [NE] = '{4'hF, 4'h1, 4'hF, 4'h0, 4'hF, 4'hF};
  logic        t_fr  [NE] = '{1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0};
  logic        t_fw  [NE] = '{1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0};

  always_comb begin
    tlb_hit = 1'b0; tlb_ppn = '0; tlb_rd_en = '0; tlb_wr_en = '0; tlb_fonr = 1'b0; tlb_fonw = 1'b0;
    for (int i = 0; i < NE; i++) begin
      if (tlb_req && tlb_vpn == t_vpn[i]) begin
        tlb_hit = 1'b1; tlb_ppn = t_ppn[i]; tlb_rd_en = t_re[i]; tlb_wr_en = t_we[i];
        tlb_fonr = t_fr[i]; tlb_fonw = t_fw[i];
      end
    end
  end

  // expected-result model built from the requirements
  function automatic void model(input logic [47:0] va, input logic [1:0] sz, input logic wr,
      input logic phys, input logic alt, input logic pte, input logic pc0,
      input logic [1:0] cur, input logic [1:0] altm,
      output logic [2:0] f, output logic [5:0] st, output logic [43:0] pa, output logic uc);
    logic [47:0] full;
    logic        have;
    int          idx;
    logic [1:0]  em;
    f = 3'd0; st = '0; pa = '0; uc = 1'b0; have = 1'b0; full = '0;
    if ((va & ((48'd1 << sz) - 48'd1)) != 0) begin
      f = 3'd1; st = {5'b0, wr};
    end else if (phys) begin
      full = va; have = 1'b1;
    end else if (!(va[47:42] == 6'h00 || va[47:42] == 6'h3F)) begin
      f = 3'd2; st = 6'h22 | {5'b0, wr};
    end else if (va[47:41] == 7'h7E) begin
      if (cur != 2'd0) begin f = 3'd3; st = 6'h02 | {5'b0, wr}; end
      else begin full = {4'h0, {4{va[40]}}, va[39:0]}; have = 1'b1; end
    end else begin
      idx = -1;
      for (int i = 0; i < NE; i++) if (t_vpn[i] == va[47:13]) idx = i;
      if (idx < 0) begin
        f = pte ? 3'd4 : 3'd5; st = 6'h10 | {5'b0, wr};
      end else begin
        em = pc0 ? (alt ? altm : 2'd0) : cur;
        full = {3'b0, t_ppn[idx], va[12:0]};
        if (wr) begin
          if (!t_we[idx][em]) begin f = 3'd2; st = t_fw[idx] ? 6'h0B : 6'h03; end
          else if (t_fw[idx]) begin f = 3'd2; st = 6'h09; end
          else have = 1'b1;
        end else begin
          if (!t_re[idx][em]) begin f = 3'd3; st = t_fr[idx] ? 6'h06 : 6'h02; end
          else if (t_fr[idx]) begin f = 3'd2; st = 6'h04; end
          else have = 1'b1;
        end
      end
    end
    if (have) begin
      if (full[47:44] != 0) begin f = 3'd6; st = '0; end
      else begin
        pa = full[43:0]; uc = pa[43];
        if (uc) pa[42:35] = '0;
      end
    end
  endfunction

  // scoreboard
  logic [53:0] exp_q [$];
  string       tag_q [$];

  task automatic send(input string tag, input logic [47:0] va, input logic [1:0] sz,
      input logic wr, input logic phys, input logic alt, input logic pte, input logic pc0,
      input logic [1:0] cur, input logic [1:0] altm);
    logic [2:0] f; logic [5:0] st; logic [43:0] pa; logic uc;
    model(va, sz, wr, phys, alt, pte, pc0, cur, altm, f, st, pa, uc);
    exp_q.push_back({f, st, uc, pa});
    tag_q.push_back(tag);
    in_va = va; in_size_log2 = sz; in_store = wr; in_phys = phys; in_alt = alt;
    in_pte = pte; pc_lsb = pc0; cur_mode = cur; alt_mode = altm; in_valid = 1'b1;
    while (!in_ready) @(negedge clk);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  function automatic logic [47:0] mkva(input logic [34:0] vpn, input logic [12:0] off);
    return {vpn, off};
  endfunction

  // result back-pressure pattern
  logic [3:0] rc = '0;
  always @(posedge clk) begin
    rc <= rc + 4'd1;
    out_ready <= (rc[1:0] != 2'b01) && (rc != 4'd6);
  end

  // monitor
  logic        stalled = 1'b0;
  logic [53:0] held;
  always @(negedge clk) begin
    if (rst_n) begin
      if (stalled) begin
        checks++;
        if (!out_valid || held != {out_fault, out_status, out_uncached, out_pa}) begin
          errors++;
          $display("FAIL R1 hold: got %h valid %0d expected %h", {out_fault, out_status, out_uncached, out_pa}, out_valid, held);
        end
      end
      stalled = out_valid && !out_ready;
      held = {out_fault, out_status, out_uncached, out_pa};
      if (out_valid && out_ready) begin
        logic [53:0] e;
        string t;
        checks++;
        if (exp_q.size() == 0) begin
          errors++;
          $display("FAIL R1 unexpected result %h expected none", {out_fault, out_status, out_uncached, out_pa});
        end else begin
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          if (e != {out_fault, out_status, out_uncached, out_pa}) begin
            errors++;
            $display("FAIL %s: fault %0d/%0d status %h/%h uc %0d/%0d pa %h/%h (actual/expected)",
              t, out_fault, e[53:51], out_status, e[50:45], out_uncached, e[44], out_pa, e[43:0]);
          end
        end
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    checks++;
    if (out_valid !== 1'b0 || in_ready !== 1'b1) begin
      errors++;
      $display("FAIL R1 reset: out_valid %b in_ready %b expected 0 1", out_valid, in_ready);
    end
    send("R7 load hit",            mkva(35'h100, 13'h1A8), 2'd3, 0, 0, 0, 0, 0, 2'd0, 2'd0);
    send("R7 store hit user",      mkva(35'h100, 13'h0F0), 2'd3, 1, 0, 0, 0, 0, 2'd3, 2'd0);
    send("R2 misaligned store",    mkva(35'h100, 13'h1A4), 2'd3, 1, 0, 0, 0, 0, 2'd0, 2'd0);
    send("R2 align before bad VA", 48'h0400_0000_0004,     2'd3, 0, 0, 0, 0, 0, 2'd0, 2'd0);
    send("R4,R13 bad VA load",     48'h0400_0000_0000,     2'd3, 0, 0, 0, 0, 0, 2'd0, 2'd0);
    send("R4 bad VA store",        48'h0400_0000_0000,     2'd2, 1, 0, 0, 0, 0, 2'd0, 2'd0);
    send("R5 superpage user",      48'hFC00_0012_3450,     2'd3, 0, 0, 0, 0, 0, 2'd3, 2'd0);
    send("R5 superpage kernel",    48'hFC00_0012_3450,     2'd3, 0, 0, 0, 0, 0, 2'd0, 2'd0);
    send("R5 superpage cur mode",  48'hFC00_0012_3450,     2'd3, 1, 0, 1, 0, 1, 2'd0, 2'd3);
    send("R5 superpage pc0 user",  48'hFC00_0012_3450,     2'd3, 0, 0, 0, 0, 1, 2'd3, 2'd0);
    send("R12 superpage bit40",    48'hFD00_0012_3450,     2'd3, 0, 0, 0, 0, 0, 2'd0, 2'd0);
    send("R6 pte miss",            mkva(35'h1FF, 13'h0),   2'd3, 0, 0, 0, 1, 0, 2'd0, 2'd0);
    send("R6 normal miss store",   mkva(35'h1FF, 13'h8),   2'd3, 1, 0, 0, 0, 0, 2'd0, 2'd0);
    send("R8 store no perm",       mkva(35'h101, 13'h10),  2'd3, 1, 0, 0, 0, 0, 2'd3, 2'd0);
    send("R8 store no perm fonw",  mkva(35'h103, 13'h10),  2'd3, 1, 0, 0, 0, 0, 2'd0, 2'd0);
    send("R8 store fonw",          mkva(35'h102, 13'h10),  2'd3, 1, 0, 0, 0, 0, 2'd0, 2'd0);
    send("R9 load no perm",        mkva(35'h101, 13'h20),  2'd3, 0, 0, 0, 0, 0, 2'd3, 2'd0);
    send("R9 load no perm fonr",   mkva(35'h103, 13'h20),  2'd3, 0, 0, 0, 0, 0, 2'd0, 2'd0);
    send("R9 load fonr",           mkva(35'h102, 13'h20),  2'd3, 0, 0, 0, 0, 0, 2'd0, 2'd0);
    send("R3 pc0 alt user",        mkva(35'h101, 13'h30),  2'd3, 0, 0, 1, 0, 1, 2'd0, 2'd3);
    send("R3 pc0 kernel",          mkva(35'h101, 13'h30),  2'd3, 0, 0, 0, 0, 1, 2'd3, 2'd3);
    send("R3 pc0 clear cur",       mkva(35'h101, 13'h31),  2'd0, 0, 0, 1, 0, 0, 2'd0, 2'd3);
    send("R10 physical",           48'h0123_4567_89A8,     2'd3, 0, 1, 0, 0, 0, 2'd3, 2'd0);
    send("R10 physical odd VA",    48'h0400_0000_0000,     2'd3, 1, 1, 0, 0, 0, 2'd3, 2'd0);
    send("R11 physical range",     48'h2000_0000_0000,     2'd3, 0, 1, 0, 0, 0, 2'd0, 2'd0);
    send("R11 hit range",          mkva(35'h104, 13'h40),  2'd3, 0, 0, 0, 0, 0, 2'd0, 2'd0);
    send("R12 hit uncached",       mkva(35'h105, 13'h48),  2'd3, 0, 0, 0, 0, 0, 2'd0, 2'd0);
    send("R12 physical uncached",  48'h0FFF_FFFF_FFF8,     2'd3, 0, 1, 0, 0, 0, 2'd0, 2'd0);
    for (int i = 0; i < 8; i++)
      send("R1 burst", mkva(35'h100, 13'(i * 8)), 2'd3, i[0], 0, 0, 0, 0, 2'd0, 2'd0);
    while (exp_q.size() != 0) @(negedge clk);
    repeat (4) @(negedge clk);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    errors++;
    $display("FAIL watchdog: run did not complete, got timeout expected finish");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule